// File: doc/BRIEF.md
# Converter-Side Chip-Select Serial Read Port

This block models the digital face of a successive-approximation converter that is read over a three-wire serial link. The link uses one convert/select line and one serial clock, and has a serial data input that is held high. A host raises the convert line to start a conversion. The block runs a conversion timer of a fixed number of clock cycles. When the timer expires, the block captures a parallel sample word as the result.

Lowering the convert line after the result is ready puts the most significant bit on the serial output and enables the output driver. Each later serial-clock falling edge moves the output to the next lower bit. The driver switches off after the eighteenth falling edge, or when the convert line rises again, whichever comes first.

The block serves as a stand-in converter for testing host-side controllers. All inputs are sampled on the block clock, and the serial output is presented as a data bit plus an active-high output enable. Each output change takes effect on the first clock edge that sees the input change.

Top module: `sar_cs_port`

## Requirements
- R1: After a synchronous reset, ser_oe is low, and it stays low until a conversion has completed and convert has fallen.
- R2: A rising edge on convert while ser_in is high starts a conversion, and ser_oe is low from the next clock onward.
- R3: A conversion lasts CONV_CYCLES clocks whatever convert does meanwhile. sample_word is captured on its final clock, and ser_oe stays low throughout.
- R4: If convert is high when a conversion completes, then on its next falling edge ser_oe goes high one clock later, with ser_out equal to bit 17 (MSB) of the captured word.
- R5: Each ser_clk falling edge seen while convert is low and ser_oe is high moves ser_out to the next lower bit (bit 16, then 15, down to bit 0). ser_clk rising edges leave ser_out unchanged.
- R6: The 18th ser_clk falling edge of a readout sets ser_oe low. Any further falling edges keep it low.
- R7: A rising edge on convert during a readout sets ser_oe low on the next clock.
- R8: If convert is low when a conversion completes, that word is never driven. ser_oe stays low under any ser_clk activity until a later conversion completes.
- R9: ser_clk edges while convert is high change neither the captured word nor the bit order of the following readout.
- R10: A rising edge on convert while ser_in is low starts no conversion. The following falling edge leaves ser_oe low.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Block clock; all inputs are sampled on its rising edge |
| rst | input | 1 | Synchronous active-high reset |
| convert | input | 1 | Convert/select line: rising starts a conversion, low selects readout |
| ser_clk | input | 1 | Serial clock from the host; falling edges advance the data |
| ser_in | input | 1 | Serial data input; must be high for chip-select operation |
| sample_word | input | WIDTH (18) | Parallel word captured when a conversion ends |
| ser_out | output | 1 | Serial data bit, meaningful while ser_oe is high |
| ser_oe | output | 1 | Output enable; low means the serial output is high impedance |

## Verification
The assertions assume that convert, ser_clk and ser_in are synchronous to clk. They also assume that each level on these inputs lasts at least one clock, so every edge is seen as exactly one change between samples, and that convert is low while reset is applied. The bench changes every input only on the falling clock edge, holds each level for at least one full clock, and releases reset with convert and ser_clk low. sample_word is held steady across each conversion, so the captured value does not depend on where the timer ends within a cycle.

// File: rtl/sarsp_pkg.sv
package sarsp_pkg;
  typedef enum logic {
    PH_ACQ  = 1'b0,
    PH_CONV = 1'b1
  } conv_phase_e;

  function automatic int unsigned cnt_bits(input int unsigned n);
    return (n > 1) ? $clog2(n) : 1;
  endfunction
endpackage

// File: rtl/sarsp_line_sampler.sv
module sarsp_line_sampler #(
  parameter int unsigned LINES = 2
) (
  input  logic             clk,
  input  logic             rst,
  input  logic [LINES-1:0] lines_i,
  output logic [LINES-1:0] prev_o
);
  for (genvar g = 0; g < LINES; g++) begin : g_line
    always_ff @(posedge clk) begin
      if (rst) prev_o[g] <= 1'b0;
      else     prev_o[g] <= lines_i[g];
    end
  end
endmodule

// File: rtl/sarsp_conv_timer.sv
module sarsp_conv_timer
  import sarsp_pkg::*;
#(
  parameter int unsigned CONV_CYCLES = 20
) (
  input  logic clk,
  input  logic rst,
  input  logic start_i,
  output logic busy_o,
  output logic done_o
);
  localparam int unsigned CW = cnt_bits(CONV_CYCLES);
  localparam logic [CW-1:0] LAST = CW'(CONV_CYCLES - 1);

  conv_phase_e    phase;
  logic [CW-1:0]  remain;

  always_ff @(posedge clk) begin
    if (rst) begin
      phase  <= PH_ACQ;
      remain <= '0;
    end else if (phase == PH_ACQ) begin
      if (start_i) begin
        phase  <= PH_CONV;
        remain <= LAST;
      end
    end else if (remain == '0) begin
      phase <= PH_ACQ;
    end else begin
      remain <= remain - 1'b1;
    end
  end

  assign busy_o = (phase == PH_CONV);
  assign done_o = (phase == PH_CONV) && (remain == '0);
endmodule

// File: rtl/sarsp_shifter.sv
module sarsp_shifter #(
  parameter int unsigned WIDTH = 18
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             load_i,
  input  logic [WIDTH-1:0] word_i,
  input  logic             shift_i,
  output logic             msb_o
);
  logic [WIDTH-1:0] bits;

  always_ff @(posedge clk) begin
    if (rst)          bits <= '0;
    else if (load_i)  bits <= word_i;
    else if (shift_i) bits <= {bits[WIDTH-2:0], 1'b0};
  end

  assign msb_o = bits[WIDTH-1];
endmodule

// File: rtl/sarsp_frame_ctrl.sv
module sarsp_frame_ctrl #(
  parameter int unsigned WIDTH = 18
) (
  input  logic clk,
  input  logic rst,
  input  logic sel_level_i,
  input  logic sel_rise_i,
  input  logic sel_fall_i,
  input  logic clk_fall_i,
  input  logic conv_busy_i,
  input  logic conv_done_i,
  output logic shift_o,
  output logic oe_o
);
  localparam int unsigned BW = (WIDTH > 1) ? $clog2(WIDTH) : 1;
  localparam logic [BW-1:0] LAST_BIT = BW'(WIDTH - 1);

  logic          armed;
  logic [BW-1:0] bit_idx;
  logic          step;

  assign step    = oe_o && clk_fall_i && !sel_level_i;
  assign shift_o = step && (bit_idx != LAST_BIT);

  always_ff @(posedge clk) begin
    if (rst) begin
      armed <= 1'b0;
    end else if (conv_done_i) begin
      armed <= sel_level_i;
    end else if (sel_rise_i || (sel_fall_i && !conv_busy_i)) begin
      armed <= 1'b0;
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      oe_o    <= 1'b0;
      bit_idx <= '0;
    end else if (sel_rise_i) begin
      oe_o <= 1'b0;
    end else if (sel_fall_i && armed && !conv_busy_i) begin
      oe_o    <= 1'b1;
      bit_idx <= '0;
    end else if (step) begin
      if (bit_idx == LAST_BIT) oe_o <= 1'b0;
      else                     bit_idx <= bit_idx + 1'b1;
    end
  end
endmodule

// File: rtl/sar_cs_port.sv
module sar_cs_port #(
  parameter int unsigned WIDTH       = 18,
  parameter int unsigned CONV_CYCLES = 20
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             convert,
  input  logic             ser_clk,
  input  logic             ser_in,
  input  logic [WIDTH-1:0] sample_word,
  output logic             ser_out,
  output logic             ser_oe
);
  localparam int unsigned SEL = 0;
  localparam int unsigned SCK = 1;

  logic [1:0] prev;
  logic       sel_rise, sel_fall, clk_fall;
  logic       conv_busy, conv_done, shift;

  sarsp_line_sampler #(.LINES(2)) u_lines (
    .clk     (clk),
    .rst     (rst),
    .lines_i ({ser_clk, convert}),
    .prev_o  (prev)
  );

  assign sel_rise = convert && !prev[SEL];
  assign sel_fall = !convert && prev[SEL];
  assign clk_fall = !ser_clk && prev[SCK];

  sarsp_conv_timer #(.CONV_CYCLES(CONV_CYCLES)) u_timer (
    .clk     (clk),
    .rst     (rst),
    .start_i (sel_rise && ser_in),
    .busy_o  (conv_busy),
    .done_o  (conv_done)
  );

  sarsp_frame_ctrl #(.WIDTH(WIDTH)) u_frame (
    .clk         (clk),
    .rst         (rst),
    .sel_level_i (convert),
    .sel_rise_i  (sel_rise),
    .sel_fall_i  (sel_fall),
    .clk_fall_i  (clk_fall),
    .conv_busy_i (conv_busy),
    .conv_done_i (conv_done),
    .shift_o     (shift),
    .oe_o        (ser_oe)
  );

  sarsp_shifter #(.WIDTH(WIDTH)) u_shift (
    .clk     (clk),
    .rst     (rst),
    .load_i  (conv_done),
    .word_i  (sample_word),
    .shift_i (shift),
    .msb_o   (ser_out)
  );
endmodule

// File: rtl/sar_cs_port_chk.sv
module sar_cs_port_chk (
  input logic clk,
  input logic rst,
  input logic convert,
  input logic ser_clk,
  input logic ser_out,
  input logic ser_oe,
  input logic busy
);
  // R7 and R2: a convert rise switches the driver off on the next clock
  p_oe_off_after_rise_r7: assert property (@(posedge clk) disable iff (rst)
    (convert && !$past(convert)) |=> !ser_oe);

  // R4: the driver is only on while convert was low at the previous sample
  p_oe_needs_low_r4: assert property (@(posedge clk) disable iff (rst)
    ser_oe |-> !$past(convert));

  // R4: the driver turns on only right after a convert fall
  p_oe_rise_on_fall_r4: assert property (@(posedge clk) disable iff (rst)
    $rose(ser_oe) |-> (!$past(convert) && $past(convert, 2)));

  // R5: without a serial clock fall, a driven bit holds
  p_out_holds_r5: assert property (@(posedge clk) disable iff (rst)
    (ser_oe && $past(ser_oe) && !(!$past(ser_clk) && $past(ser_clk, 2)))
      |-> $stable(ser_out));

  // R3: nothing is driven while a conversion runs
  p_quiet_in_conv_r3: assert property (@(posedge clk) disable iff (rst)
    busy |-> !ser_oe);
endmodule

bind sar_cs_port sar_cs_port_chk u_chk (
  .clk     (clk),
  .rst     (rst),
  .convert (convert),
  .ser_clk (ser_clk),
  .ser_out (ser_out),
  .ser_oe  (ser_oe),
  .busy    (conv_busy)
);

// File: tb/tb_sar_cs_port.sv
`timescale 1ns/1ps
module tb_sar_cs_port;
  localparam int W    = 18;
  localparam int CONV = 12;
  localparam int NV   = 6;
  localparam logic [W-1:0] VEC [NV] = '{18'h3FFFF, 18'h00000, 18'h2AAAA,
                                        18'h15555, 18'h20001, 18'h1E2D4};

  logic clk = 1'b0, rst = 1'b1, convert = 1'b0, ser_clk = 1'b0, ser_in = 1'b1;
  logic [W-1:0] sample_word = '0;
  logic ser_out, ser_oe;
  int   n_run = 0, n_fail = 0;
  bit   finished = 1'b0;

  sar_cs_port #(.WIDTH(W), .CONV_CYCLES(CONV)) dut (
    .clk(clk), .rst(rst), .convert(convert), .ser_clk(ser_clk), .ser_in(ser_in),
    .sample_word(sample_word), .ser_out(ser_out), .ser_oe(ser_oe));

  always #2.5 clk = ~clk;

  task automatic tick(input int n = 1);
    repeat (n) @(negedge clk);
  endtask

  task automatic check(input bit ok, input string req, input logic [W-1:0] act,
                       input logic [W-1:0] exp);
    n_run++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic sck_pulse();
    ser_clk = 1'b1; tick();
    ser_clk = 1'b0; tick();
  endtask

  // convert rises with the given sample, held through the conversion
  task automatic convert_word(input logic [W-1:0] s);
    sample_word = s;
    convert = 1'b1;
    tick(CONV + 3);
  endtask

  // lowers convert and reads all bits; counts enable anomalies
  task automatic read_word(output logic [W-1:0] w, output int bad);
    bad = 0;
    convert = 1'b0; tick();
    if (!ser_oe) bad++;
    w[W-1] = ser_out;
    for (int i = W - 2; i >= 0; i--) begin
      sck_pulse();
      if (!ser_oe) bad++;
      w[i] = ser_out;
    end
    sck_pulse();
    if (ser_oe) bad++;
  endtask

  initial begin
    logic [W-1:0] got;
    int bad;
    logic b0;

    tick(4);
    check(ser_oe == 1'b0, "R1 reset oe", W'(ser_oe), '0);
    rst = 1'b0; tick(2);
    convert = 1'b1; tick(2); convert = 1'b0; tick(2);
    check(ser_oe == 1'b0, "R1 no drive before completion", W'(ser_oe), '0);
    tick(CONV);

    // table walk: R2 R4 R5 R6
    for (int v = 0; v < NV; v++) begin
      convert_word(VEC[v]);
      check(ser_oe == 1'b0, "R2 oe low after rise", W'(ser_oe), '0);
      read_word(got, bad);
      check(got == VEC[v], "R4/R5 word bits", got, VEC[v]);
      check(bad == 0, "R6 enable window", W'(bad), '0);
      tick(2);
    end

    // R6: extra falls keep the driver off
    repeat (3) sck_pulse();
    check(ser_oe == 1'b0, "R6 extra falls", W'(ser_oe), '0);

    // R5: a rising edge alone does not move the bit
    convert_word(18'h2AAAA);
    convert = 1'b0; tick();
    b0 = ser_out;
    ser_clk = 1'b1; tick(3);
    check(ser_out == b0 && ser_oe, "R5 rise no shift", W'(ser_out), W'(b0));
    ser_clk = 1'b0; tick();
    check(ser_out == 1'b0, "R5 fall shifts to bit16", W'(ser_out), '0);

    // R7: convert rises mid-readout
    sck_pulse(); sck_pulse();
    convert = 1'b1; tick();
    check(ser_oe == 1'b0, "R7 rise ends readout", W'(ser_oe), '0);
    tick(CONV + 3);
    sample_word = 18'h00F0F;
    read_word(got, bad);
    check(got == 18'h2AAAA && bad == 0, "R7 next conversion readable", got, 18'h2AAAA);

    // R3: convert lowered during conversion, then back high before the end
    tick(2);
    sample_word = 18'h0C3A5;
    convert = 1'b1; tick(2);
    convert = 1'b0; tick(3);
    check(ser_oe == 1'b0, "R3 quiet while converting", W'(ser_oe), '0);
    convert = 1'b1; tick(CONV);
    sample_word = 18'h3FFFF;
    read_word(got, bad);
    check(got == 18'h0C3A5 && bad == 0, "R3 captured at completion", got, 18'h0C3A5);

    // R8: convert low at completion
    tick(2);
    sample_word = 18'h12345;
    convert = 1'b1; tick(2);
    convert = 1'b0; tick(CONV + 3);
    repeat (4) sck_pulse();
    check(ser_oe == 1'b0, "R8 unread word never driven", W'(ser_oe), '0);

    // R9: clock activity while convert is high
    sample_word = 18'h2D2D2;
    convert = 1'b1; tick(CONV + 3);
    repeat (5) sck_pulse();
    read_word(got, bad);
    check(got == 18'h2D2D2 && bad == 0, "R9 high-select clocks ignored", got, 18'h2D2D2);

    // R10: ser_in low blocks a conversion
    tick(2);
    ser_in = 1'b0;
    sample_word = 18'h33333;
    convert = 1'b1; tick(CONV + 3);
    convert = 1'b0; tick(2);
    check(ser_oe == 1'b0, "R10 no conversion with ser_in low", W'(ser_oe), '0);
    ser_in = 1'b1;

    // R1: reset in the middle of a readout
    convert_word(18'h3C3C3);
    convert = 1'b0; tick();
    rst = 1'b1; tick(2);
    check(ser_oe == 1'b0, "R1 reset clears driver", W'(ser_oe), '0);
    rst = 1'b0; tick(2);

    finished = 1'b1;
    $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end

  initial begin
    #(200000 * 5);
    if (!finished) begin
      n_run++;
      n_fail++;
      $display("FAIL watchdog actual=timeout expected=completion");
      $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
      $finish;
    end
  end
endmodule